// File: doc/BRIEF.md
# Boot-Selectable Memory Alias Decoder

This block translates a 32-bit bus address into a memory target and a byte offset within that target. It is purely combinational and sits between the interconnect and the memory arrays. A two-bit mapping mode chooses which memory shows through at the bottom of the address space. A bank-swap bit chooses which of two program-flash banks, and which of two data-EEPROM banks, sits at the primary base address.

The low alias region shows a different memory in each mode. In main mode it shows the program and EEPROM windows at their low addresses. In system mode it shows system flash, and in SRAM mode it shows SRAM. The reserved mode code maps nothing there and flags an error. The direct windows of every memory are always decoded. The bank that is swapped out stays reachable at the second bank's normal base, so both banks can be addressed in every setting. A build parameter can remove the swap function, and the swap input is then ignored.

Top module: `memmap_alias_dec`

## Requirements
- R1: Target codes on `tgt_o` are 0 none, 1 program bank 1, 2 program bank 2, 3 system flash, 4 SRAM, 5 EEPROM bank 1, 6 EEPROM bank 2. `hit_o` is 1 exactly when `tgt_o` is not 0.
- R2: With swap 0, program bank 1 occupies 0x0800_0000 to 0x0800_0000+PROG_BYTES-1 and bank 2 follows it directly. The offset is the address minus the window base.
- R3: With swap 0, EEPROM bank 1 occupies 0x0808_0000 to 0x0808_0000+EEP_BYTES-1 and bank 2 follows it directly.
- R4: With swap 1 and HAS_SWAP=1, bank 2 and bank 1 trade places in both the program windows and the EEPROM windows. This holds for the direct windows and for the low aliases.
- R5: In mode 00, addresses 0 to 2*PROG_BYTES-1 alias the two program windows. Addresses from 0x0008_0000 to 0x0008_0000+2*EEP_BYTES-1 alias the two EEPROM windows. The offsets match the direct windows.
- R6: In mode 01, addresses 0 to SYS_BYTES-1 select system flash. In mode 11, addresses 0 to SRAM_BYTES-1 select SRAM. In both cases the offset equals the address.
- R7: In mode 10, any address below ALIAS_BYTES (default 0x0010_0000) gives target 0 with `map_err_o`=1. `map_err_o` is 0 in every other case.
- R8: System flash at 0x1FF0_0000 and SRAM at 0x2000_0000 are decoded in every mode. The offset is taken from the window base.
- R9: An address outside every active window gives target 0, offset 0, `hit_o`=0. This includes the byte just past the end of a window and the parts of the alias region that the current mode leaves empty.
- R10: With HAS_SWAP=0, `bank_swap_i` has no effect and the decode always uses swap 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 32 | Bus byte address |
| map_mode_i | input | 2 | Low-region mapping mode |
| bank_swap_i | input | 1 | Exchange bank 1 and bank 2 of program and EEPROM |
| tgt_o | output | 3 | Selected target code |
| ofs_o | output | OFS_W | Byte offset inside the selected target |
| hit_o | output | 1 | Some target selected |
| map_err_o | output | 1 | Access to the low region under the reserved mode |

## Verification
Every output follows its inputs within the same cycle, because no register lies between the ports. The bench therefore applies a new address, mode and swap value on the falling clock edge. It samples all four outputs one nanosecond later, well before the next rising edge, so each result is read after the logic has settled on the current stimulus. The same stimulus also drives a second instance built without the swap option. That instance is compared against the decode expected with swap forced to 0.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

    typedef enum logic [2:0] {
        TGT_NONE  = 3'd0,
        TGT_PROG1 = 3'd1,
        TGT_PROG2 = 3'd2,
        TGT_SYS   = 3'd3,
        TGT_SRAM  = 3'd4,
        TGT_EEP1  = 3'd5,
        TGT_EEP2  = 3'd6
    } target_e;

    typedef enum logic [1:0] {
        MAP_MAIN = 2'b00,
        MAP_SYS  = 2'b01,
        MAP_RSVD = 2'b10,
        MAP_SRAM = 2'b11
    } map_mode_e;

    localparam logic [31:0] PROG_BASE = 32'h0800_0000;
    localparam logic [31:0] EEP_BASE  = 32'h0808_0000;
    localparam logic [31:0] SYS_BASE  = 32'h1FF0_0000;
    localparam logic [31:0] SRAM_BASE = 32'h2000_0000;
    localparam logic [31:0] ZEEP_BASE = 32'h0008_0000;

    // Window slots, decoded in parallel
    localparam int W_PROG_A  = 0;
    localparam int W_PROG_B  = 1;
    localparam int W_EEP_A   = 2;
    localparam int W_EEP_B   = 3;
    localparam int W_SYS     = 4;
    localparam int W_SRAM    = 5;
    localparam int W_ZPROG_A = 6;
    localparam int W_ZPROG_B = 7;
    localparam int W_ZEEP_A  = 8;
    localparam int W_ZEEP_B  = 9;
    localparam int W_ZSYS    = 10;
    localparam int W_ZSRAM   = 11;
    localparam int W_ZERO    = 12;
    localparam int NWIN      = 13;

    function automatic logic [31:0] win_base(int idx, int unsigned p, int unsigned e);
        case (idx)
            W_PROG_A:  return PROG_BASE;
            W_PROG_B:  return PROG_BASE + 32'(p);
            W_EEP_A:   return EEP_BASE;
            W_EEP_B:   return EEP_BASE + 32'(e);
            W_SYS:     return SYS_BASE;
            W_SRAM:    return SRAM_BASE;
            W_ZPROG_B: return 32'(p);
            W_ZEEP_A:  return ZEEP_BASE;
            W_ZEEP_B:  return ZEEP_BASE + 32'(e);
            default:   return 32'h0;
        endcase
    endfunction

    function automatic int unsigned win_size(int idx, int unsigned p, int unsigned e,
                                             int unsigned s, int unsigned r, int unsigned z);
        case (idx)
            W_PROG_A, W_PROG_B, W_ZPROG_A, W_ZPROG_B: return p;
            W_EEP_A, W_EEP_B, W_ZEEP_A, W_ZEEP_B:     return e;
            W_SYS, W_ZSYS:                            return s;
            W_SRAM, W_ZSRAM:                          return r;
            default:                                  return z;
        endcase
    endfunction

    function automatic int unsigned max4(int unsigned a, int unsigned b,
                                         int unsigned c, int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/memmap_window.sv
module memmap_window #(
    parameter logic [31:0] BASE  = 32'h0,
    parameter int unsigned SIZE  = 1024,
    parameter int          OFS_W = 16
) (
    input  logic [31:0]      addr_i,
    output logic             hit_o,
    output logic [OFS_W-1:0] ofs_o
);
    localparam logic [32:0] LIMIT = {1'b0, BASE} + 33'(SIZE);

    logic [31:0] diff;

    always_comb begin
        diff  = addr_i - BASE;
        hit_o = ({1'b0, addr_i} >= {1'b0, BASE}) && ({1'b0, addr_i} < LIMIT);
        ofs_o = hit_o ? diff[OFS_W-1:0] : '0;
    end
endmodule

// File: rtl/memmap_bank_swap.sv
module memmap_bank_swap
    import memmap_pkg::*;
#(
    parameter bit HAS_SWAP = 1'b1
) (
    input  logic    swap_i,
    output target_e prog_a_o,
    output target_e prog_b_o,
    output target_e eep_a_o,
    output target_e eep_b_o
);
    logic swap_eff;

    generate
        if (HAS_SWAP) begin : g_swap
            assign swap_eff = swap_i;
        end else begin : g_noswap
            assign swap_eff = 1'b0;
        end
    endgenerate

    always_comb begin
        prog_a_o = swap_eff ? TGT_PROG2 : TGT_PROG1;
        prog_b_o = swap_eff ? TGT_PROG1 : TGT_PROG2;
        eep_a_o  = swap_eff ? TGT_EEP2  : TGT_EEP1;
        eep_b_o  = swap_eff ? TGT_EEP1  : TGT_EEP2;
    end
endmodule

// File: rtl/memmap_route.sv
module memmap_route
    import memmap_pkg::*;
#(
    parameter int OFS_W = 16
) (
    input  logic [NWIN-1:0]            hit_i,
    input  logic [NWIN-1:0][OFS_W-1:0] ofs_i,
    input  logic [1:0]                 mode_i,
    input  target_e                    prog_a_i,
    input  target_e                    prog_b_i,
    input  target_e                    eep_a_i,
    input  target_e                    eep_b_i,
    output target_e                    tgt_o,
    output logic [OFS_W-1:0]           ofs_o,
    output logic                       err_o
);
    always_comb begin
        tgt_o = TGT_NONE;
        ofs_o = '0;
        err_o = 1'b0;
        // Direct windows never overlap the low region
        if (hit_i[W_PROG_A]) begin
            tgt_o = prog_a_i; ofs_o = ofs_i[W_PROG_A];
        end else if (hit_i[W_PROG_B]) begin
            tgt_o = prog_b_i; ofs_o = ofs_i[W_PROG_B];
        end else if (hit_i[W_EEP_A]) begin
            tgt_o = eep_a_i;  ofs_o = ofs_i[W_EEP_A];
        end else if (hit_i[W_EEP_B]) begin
            tgt_o = eep_b_i;  ofs_o = ofs_i[W_EEP_B];
        end else if (hit_i[W_SYS]) begin
            tgt_o = TGT_SYS;  ofs_o = ofs_i[W_SYS];
        end else if (hit_i[W_SRAM]) begin
            tgt_o = TGT_SRAM; ofs_o = ofs_i[W_SRAM];
        end else if (hit_i[W_ZERO]) begin
            case (map_mode_e'(mode_i))
                MAP_MAIN: begin
                    if (hit_i[W_ZPROG_A]) begin
                        tgt_o = prog_a_i; ofs_o = ofs_i[W_ZPROG_A];
                    end else if (hit_i[W_ZPROG_B]) begin
                        tgt_o = prog_b_i; ofs_o = ofs_i[W_ZPROG_B];
                    end else if (hit_i[W_ZEEP_A]) begin
                        tgt_o = eep_a_i;  ofs_o = ofs_i[W_ZEEP_A];
                    end else if (hit_i[W_ZEEP_B]) begin
                        tgt_o = eep_b_i;  ofs_o = ofs_i[W_ZEEP_B];
                    end
                end
                MAP_SYS: begin
                    if (hit_i[W_ZSYS]) begin
                        tgt_o = TGT_SYS; ofs_o = ofs_i[W_ZSYS];
                    end
                end
                MAP_SRAM: begin
                    if (hit_i[W_ZSRAM]) begin
                        tgt_o = TGT_SRAM; ofs_o = ofs_i[W_ZSRAM];
                    end
                end
                default: err_o = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/memmap_alias_dec.sv
module memmap_alias_dec
    import memmap_pkg::*;
#(
    parameter int unsigned PROG_BYTES  = 65536,
    parameter int unsigned EEP_BYTES   = 3072,
    parameter int unsigned SYS_BYTES   = 8192,
    parameter int unsigned SRAM_BYTES  = 20480,
    parameter int unsigned ALIAS_BYTES = 32'h0010_0000,
    parameter bit          HAS_SWAP    = 1'b1,
    parameter int OFS_W = $clog2(max4(PROG_BYTES, EEP_BYTES, SYS_BYTES, SRAM_BYTES))
) (
    input  logic [31:0]      addr_i,
    input  logic [1:0]       map_mode_i,
    input  logic             bank_swap_i,
    output logic [2:0]       tgt_o,
    output logic [OFS_W-1:0] ofs_o,
    output logic             hit_o,
    output logic             map_err_o
);
    logic [NWIN-1:0]            win_hit;
    logic [NWIN-1:0][OFS_W-1:0] win_ofs;
    target_e prog_a, prog_b, eep_a, eep_b, tgt;

    generate
        for (genvar w = 0; w < NWIN; w++) begin : g_win
            memmap_window #(
                .BASE (win_base(w, PROG_BYTES, EEP_BYTES)),
                .SIZE (win_size(w, PROG_BYTES, EEP_BYTES, SYS_BYTES, SRAM_BYTES, ALIAS_BYTES)),
                .OFS_W(OFS_W)
            ) win_i (
                .addr_i(addr_i),
                .hit_o (win_hit[w]),
                .ofs_o (win_ofs[w])
            );
        end
    endgenerate

    memmap_bank_swap #(.HAS_SWAP(HAS_SWAP)) swap_i (
        .swap_i  (bank_swap_i),
        .prog_a_o(prog_a),
        .prog_b_o(prog_b),
        .eep_a_o (eep_a),
        .eep_b_o (eep_b)
    );

    memmap_route #(.OFS_W(OFS_W)) route_i (
        .hit_i   (win_hit),
        .ofs_i   (win_ofs),
        .mode_i  (map_mode_i),
        .prog_a_i(prog_a),
        .prog_b_i(prog_b),
        .eep_a_i (eep_a),
        .eep_b_i (eep_b),
        .tgt_o   (tgt),
        .ofs_o   (ofs_o),
        .err_o   (map_err_o)
    );

    assign tgt_o = tgt;
    assign hit_o = (tgt != TGT_NONE);
endmodule

// File: rtl/memmap_alias_chk.sv
module memmap_alias_chk #(
    parameter int unsigned PROG_BYTES  = 65536,
    parameter int unsigned EEP_BYTES   = 3072,
    parameter int unsigned ALIAS_BYTES = 32'h0010_0000,
    parameter bit          HAS_SWAP    = 1'b1,
    parameter int          OFS_W       = 16
) (
    input logic [31:0]      addr_i,
    input logic [1:0]       map_mode_i,
    input logic             bank_swap_i,
    input logic [2:0]       tgt_o,
    input logic [OFS_W-1:0] ofs_o,
    input logic             hit_o,
    input logic             map_err_o
);
    logic sw, in_prog_a, in_low;

    always_comb begin
        sw        = HAS_SWAP ? bank_swap_i : 1'b0;
        in_prog_a = (addr_i >= 32'h0800_0000) && (addr_i < 32'h0800_0000 + 32'(PROG_BYTES));
        in_low    = (addr_i < 32'(ALIAS_BYTES));

        AST_HIT_TRACKS_TGT: assert (hit_o == (tgt_o != 3'd0)); // R1
        AST_ERR_ONLY_RSVD_LOW: assert (!map_err_o || (map_mode_i == 2'b10 && in_low)); // R7
        AST_ERR_NO_TARGET: assert (!map_err_o || !hit_o); // R7
        AST_PRIMARY_BANK: assert (!in_prog_a || tgt_o == (sw ? 3'd2 : 3'd1)); // R4
        AST_NONE_ZERO_OFS: assert (hit_o || ofs_o == '0); // R9
        AST_CODE_LEGAL: assert (tgt_o != 3'd7); // R1
    end
endmodule

bind memmap_alias_dec memmap_alias_chk #(
    .PROG_BYTES (PROG_BYTES),
    .EEP_BYTES  (EEP_BYTES),
    .ALIAS_BYTES(ALIAS_BYTES),
    .HAS_SWAP   (HAS_SWAP),
    .OFS_W      (OFS_W)
) chk_i (
    .addr_i     (addr_i),
    .map_mode_i (map_mode_i),
    .bank_swap_i(bank_swap_i),
    .tgt_o      (tgt_o),
    .ofs_o      (ofs_o),
    .hit_o      (hit_o),
    .map_err_o  (map_err_o)
);

// File: tb/memmap_alias_dec_tb.sv
module memmap_alias_dec_tb_top;
    localparam int unsigned P = 65536;
    localparam int unsigned E = 3072;
    localparam int unsigned S = 8192;
    localparam int unsigned R = 20480;
    localparam int unsigned Z = 32'h0010_0000;

    typedef struct packed {
        logic [2:0]  tgt;
        logic [15:0] ofs;
        logic        err;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] addr = '0;
    logic [1:0]  mode = '0;
    logic        swp  = 1'b0;
    logic [2:0]  tgt_a, tgt_b;
    logic [15:0] ofs_a, ofs_b;
    logic        hit_a, hit_b, err_a, err_b;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done  = 1'b0;

    always #2 clk = ~clk;

    memmap_alias_dec dut_i (
        .addr_i(addr), .map_mode_i(mode), .bank_swap_i(swp),
        .tgt_o(tgt_a), .ofs_o(ofs_a), .hit_o(hit_a), .map_err_o(err_a)
    );

    memmap_alias_dec #(.HAS_SWAP(1'b0)) dut_ns_i (
        .addr_i(addr), .map_mode_i(mode), .bank_swap_i(swp),
        .tgt_o(tgt_b), .ofs_o(ofs_b), .hit_o(hit_b), .map_err_o(err_b)
    );

    function automatic bit inw(logic [31:0] a, logic [31:0] b, int unsigned sz);
        return ({1'b0, a} >= {1'b0, b}) && ({1'b0, a} < {1'b0, b} + 33'(sz));
    endfunction

    function automatic exp_t mk(logic [2:0] t, logic [31:0] o, logic e);
        exp_t x;
        x.tgt = t; x.ofs = o[15:0]; x.err = e;
        return x;
    endfunction

    // Expected decode from the requirement text
    function automatic exp_t ref_dec(logic [31:0] a, logic [1:0] m, logic s);
        logic [2:0] p1, p2, e1, e2;
        p1 = s ? 3'd2 : 3'd1;  p2 = s ? 3'd1 : 3'd2;
        e1 = s ? 3'd6 : 3'd5;  e2 = s ? 3'd5 : 3'd6;
        if (inw(a, 32'h0800_0000, P))      return mk(p1, a - 32'h0800_0000, 1'b0);
        if (inw(a, 32'h0800_0000 + P, P))  return mk(p2, a - 32'h0800_0000 - P, 1'b0);
        if (inw(a, 32'h0808_0000, E))      return mk(e1, a - 32'h0808_0000, 1'b0);
        if (inw(a, 32'h0808_0000 + E, E))  return mk(e2, a - 32'h0808_0000 - E, 1'b0);
        if (inw(a, 32'h1FF0_0000, S))      return mk(3'd3, a - 32'h1FF0_0000, 1'b0);
        if (inw(a, 32'h2000_0000, R))      return mk(3'd4, a - 32'h2000_0000, 1'b0);
        if (a < Z) begin
            if (m == 2'b10) return mk(3'd0, 0, 1'b1);
            if (m == 2'b01 && a < S) return mk(3'd3, a, 1'b0);
            if (m == 2'b11 && a < R) return mk(3'd4, a, 1'b0);
            if (m == 2'b00) begin
                if (a < P)                        return mk(p1, a, 1'b0);
                if (a < 2 * P)                    return mk(p2, a - P, 1'b0);
                if (inw(a, 32'h0008_0000, E))     return mk(e1, a - 32'h0008_0000, 1'b0);
                if (inw(a, 32'h0008_0000 + E, E)) return mk(e2, a - 32'h0008_0000 - E, 1'b0);
            end
        end
        return mk(3'd0, 0, 1'b0);
    endfunction

    function automatic string req_of(logic [31:0] a, logic [1:0] m, logic s, exp_t x);
        if (x.err || (m == 2'b10 && a < Z)) return "R7";
        if (x.tgt == 3'd0) return "R9";
        if (a >= 32'h1FF0_0000) return "R8";
        if (a < Z) return (m == 2'b00) ? "R5" : "R6";
        if (s) return "R4";
        return (x.tgt == 3'd5 || x.tgt == 3'd6) ? "R3" : "R2";
    endfunction

    task automatic apply(logic [31:0] a, logic [1:0] m, logic s);
        exp_t  xa, xb;
        string rq;
        @(negedge clk);
        addr = a; mode = m; swp = s;
        #1;
        xa = ref_dec(a, m, s);
        xb = ref_dec(a, m, 1'b0);
        rq = req_of(a, m, s, xa);
        n_chk++;
        if (tgt_a !== xa.tgt || ofs_a !== xa.ofs || err_a !== xa.err) begin
            n_err++;
            $display("FAIL %s addr=%h mode=%0d swap=%0d actual tgt=%0d ofs=%h err=%0b expected tgt=%0d ofs=%h err=%0b",
                     rq, a, m, s, tgt_a, ofs_a, err_a, xa.tgt, xa.ofs, xa.err);
        end
        n_chk++;
        if (hit_a !== (xa.tgt != 3'd0)) begin // R1
            n_err++;
            $display("FAIL R1 addr=%h actual hit=%0b expected %0b", a, hit_a, xa.tgt != 3'd0);
        end
        n_chk++;
        if (tgt_b !== xb.tgt || ofs_b !== xb.ofs || err_b !== xb.err) begin // R10
            n_err++;
            $display("FAIL R10 addr=%h mode=%0d swap=%0d actual tgt=%0d ofs=%h expected tgt=%0d ofs=%h",
                     a, m, s, tgt_b, ofs_b, xb.tgt, xb.ofs);
        end
    endtask

    initial begin : watchdog
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_err++;
                $display("FAIL watchdog expired after %0d cycles", cyc);
                $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
                $finish;
            end
        end
    end

    initial begin : stim
        logic [31:0] edges [0:21];
        logic [31:0] bases [0:9];
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Idle state: address 0, main mode, no swap -> bank 1 offset 0 (R5)
        apply(32'h0, 2'b00, 1'b0);
        edges = '{32'h0, P - 1, P, 2 * P - 1, 2 * P, S - 1, S, R - 1, R,
                  32'h0008_0000 - 1, 32'h0008_0000, 32'h0008_0000 + 2 * E - 1,
                  32'h0008_0000 + 2 * E, Z - 1, Z,
                  32'h0800_0000 - 1, 32'h0800_0000, 32'h0800_0000 + 2 * P - 1,
                  32'h0800_0000 + 2 * P, 32'h0808_0000 + E, 32'h1FF0_0000 + S,
                  32'h2000_0000 + R - 1};
        // Directed window edges across all mode and swap combinations (R2..R9)
        for (int m = 0; m < 4; m++)
            for (int s = 0; s < 2; s++)
                for (int i = 0; i < 22; i++)
                    apply(edges[i], 2'(m), 1'(s));
        apply(32'h0808_0000 + 2 * E - 1, 2'b00, 1'b1); // R4 EEPROM bank 1 moved up
        apply(32'h1FF0_0000, 2'b10, 1'b1);             // R8 direct system flash
        apply(32'hFFFF_FFFF, 2'b00, 1'b0);             // R9 top of space
        // Random addresses near each window base
        bases = '{32'h0, P, 32'h0008_0000, 32'h0800_0000, 32'h0800_0000 + P,
                  32'h0808_0000, 32'h0808_0000 + E, 32'h1FF0_0000, 32'h2000_0000, Z};
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] a;
            a = bases[$urandom % 10] + ($urandom % (2 * P)) - 32'd256;
            apply(a, 2'($urandom), 1'($urandom));
        end
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule